// File: doc/BRIEF.md
# CAN Mailbox Acceptance Filter and Transmit Arbiter

This block keeps the descriptor state of sixteen message buffers for a CAN controller. Each buffer can be switched off, set to receive, or marked as a pending transmission. It holds an identifier and an identifier-format flag. Software programs buffers, identifiers and acceptance masks through a single register write port. The bit engine does two things with it. It presents every received identifier on a strobe and learns which buffer accepts the frame. It also learns which pending buffer should be sent next, and it reports the end of each transmission with a completion strobe.

Receive filtering uses three masks. One is shared by the low fourteen buffers, and the top two buffers each have their own. An accepted frame marks its buffer full and stamps it with a free-running 16-bit cycle counter. A frame that only matches full buffers raises an overrun flag instead. Transmit arbitration works in one of two modes, chosen at run time: lowest buffer index, or lowest identifier with standard frames aligned to the top of the extended range. Each buffer has an interrupt flag that software can gate with an enable bit.

Top module: `can_mbox_filter`

## Requirements
- R1: After reset every buffer is inactive, all three masks are all ones, index priority is selected, and rx_hit_valid, tx_next_valid, irq_o and ovr_o are zero. A control write (wr_sel 0) loads code from wr_data[1:0] (0 inactive, 1 receive empty, 2 receive full, 3 transmit pending), the identifier format from wr_data[2] (1 extended), and the interrupt enable from wr_data[3]. It also clears that buffer's interrupt and overrun flags.
- R2: A receive buffer matches when its format flag equals rx_ide and every identifier bit where the mask is 1 agrees. Extended frames compare bits 28:0, standard frames compare bits 10:0, and mask bits at 0 are don't care.
- R3: A mask write (wr_sel 2) with wr_idx 0 sets the mask used by buffers 0 to 13, wr_idx 1 sets the mask of buffer 14, and wr_idx 2 sets the mask of buffer 15. wr_idx 3 is ignored. An identifier write (wr_sel 1) loads wr_data[28:0].
- R4: The lowest-numbered matching buffer with code receive-empty takes the frame. Its code becomes receive-full, and one clock after the rx_valid cycle rx_hit_valid pulses with rx_hit_idx set to that buffer.
- R5: When matching buffers exist but all are full, no hit is reported and the overrun flag of the lowest-numbered matching buffer is set.
- R6: rx_stamp carries the value of a counter that increments every clock, sampled at the accepting edge. The stamps of two accepted frames therefore differ by the number of clocks between them, modulo 2^16.
- R7: Inactive and transmit buffers never take part in receive matching. Inactive and receive buffers never take part in transmit selection.
- R8: With index priority (config write, wr_sel 3, wr_data[0]=0), the lowest-numbered pending buffer is selected.
- R9: With identifier priority (wr_data[0]=1), the selected buffer has the smallest key. The key of an extended frame is its 29-bit identifier; the key of a standard frame is its 11-bit identifier placed in bits 28:18. On equal keys the standard frame wins, and after that the lower index wins.
- R10: The transmit outputs change only two clock edges after the edge that samples a control write, a config write or tx_done. An identifier write alone leaves them unchanged.
- R11: tx_done while tx_next_valid is high makes the selected buffer inactive and sets its interrupt flag.
- R12: irq_o[i] is the interrupt flag of buffer i gated by its enable bit. The flag is set on frame acceptance and on transmit completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 identifier, 2 mask, 3 config |
| wr_idx | input | 4 | Buffer index, or mask index for mask writes |
| wr_data | input | 32 | Write data |
| rx_valid | input | 1 | Received identifier strobe |
| rx_id | input | 29 | Received identifier (standard in bits 10:0) |
| rx_ide | input | 1 | Received frame is extended |
| tx_done | input | 1 | Transmission of the selected buffer completed |
| rx_hit_valid | output | 1 | Frame accepted pulse |
| rx_hit_idx | output | 4 | Accepting buffer |
| rx_stamp | output | 16 | Timer value at acceptance |
| tx_next_valid | output | 1 | A pending buffer is selected |
| tx_next_idx | output | 4 | Selected transmit buffer |
| irq_o | output | 16 | Gated interrupt flags |
| ovr_o | output | 16 | Overrun flags |

## Verification
The hardest case to reach is the overrun path. Every buffer that matches a frame must already be full while lower buffers either mismatch through the mask or sit in another mode. The directed part sets this up on purpose: a frame fills the lowest buffer, and a second frame with the same identifier finds only full matches. The random part keeps identifiers and masks within four low bits, so frames often land on several buffers at once and buffers fill up over time. Equal keys across formats under identifier priority are also set up directly, as is the stale selection after an identifier-only write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;
  localparam int KEY_W = ID_W + 1;

  typedef enum logic [1:0] {
    MB_OFF      = 2'd0,
    MB_RX_EMPTY = 2'd1,
    MB_RX_FULL  = 2'd2,
    MB_TX_PEND  = 2'd3
  } mb_code_e;

  typedef enum logic [1:0] {
    WS_CTRL = 2'd0,
    WS_ID   = 2'd1,
    WS_MASK = 2'd2,
    WS_CFG  = 2'd3
  } wr_sel_e;

  typedef struct packed {
    mb_code_e code;
    logic     ext;
    logic     ien;
  } mb_ctrl_t;
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mbx_rx_match.sv
module mbx_rx_match
  import mbx_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  mb_ctrl_t             ctrl_i [NUM_MB],
  input  logic [ID_W-1:0]      id_i   [NUM_MB],
  input  logic [ID_W-1:0]      mask_i [NUM_MB],
  input  logic [ID_W-1:0]      rx_id_i,
  input  logic                 rx_ide_i,
  output logic                 hit_o,
  output logic [IDX_W-1:0]     hit_idx_o,
  output logic                 any_o,
  output logic [IDX_W-1:0]     first_idx_o
);
  logic [NUM_MB-1:0] match_vec;
  logic [NUM_MB-1:0] empty_vec;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_cmp
    logic [ID_W-1:0] diff;
    logic            is_rx;
    logic            bits_ok;
    assign diff    = (rx_id_i ^ id_i[g]) & mask_i[g];
    assign is_rx   = (ctrl_i[g].code == MB_RX_EMPTY) || (ctrl_i[g].code == MB_RX_FULL);
    assign bits_ok = rx_ide_i ? (diff == '0) : (diff[STD_W-1:0] == '0);
    assign match_vec[g] = is_rx && (ctrl_i[g].ext == rx_ide_i) && bits_ok;
    assign empty_vec[g] = ctrl_i[g].code == MB_RX_EMPTY;
  end

  always_comb begin
    hit_o       = 1'b0;
    hit_idx_o   = '0;
    any_o       = 1'b0;
    first_idx_o = '0;
    for (int i = NUM_MB - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        any_o       = 1'b1;
        first_idx_o = IDX_W'(i);
      end
      if (match_vec[i] && empty_vec[i]) begin
        hit_o     = 1'b1;
        hit_idx_o = IDX_W'(i);
      end
    end
  end

  // R4
  rx_hit_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (match_vec[hit_idx_o] && empty_vec[hit_idx_o] &&
               ((match_vec & empty_vec & ((NUM_MB'(1) << hit_idx_o) - NUM_MB'(1))) == '0)));

  // R5
  rx_first_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> (match_vec[first_idx_o] &&
               ((match_vec & ((NUM_MB'(1) << first_idx_o) - NUM_MB'(1))) == '0)));
endmodule

// File: rtl/mbx_tx_pick.sv
module mbx_tx_pick
  import mbx_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int IDX_W = $clog2(NUM_MB)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MB-1:0]    pend_i,
  input  logic [KEY_W-1:0]     key_i [NUM_MB],
  input  logic                 by_id_i,
  output logic                 valid_o,
  output logic [IDX_W-1:0]     idx_o
);
  logic [KEY_W-1:0] best_key;

  always_comb begin
    valid_o  = 1'b0;
    idx_o    = '0;
    best_key = '0;
    for (int i = 0; i < NUM_MB; i++) begin
      if (pend_i[i] && (!valid_o || (by_id_i && (key_i[i] < best_key)))) begin
        valid_o  = 1'b1;
        idx_o    = IDX_W'(i);
        best_key = key_i[i];
      end
    end
  end

  // R7
  tx_pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> pend_i[idx_o]);

  // R8
  tx_index_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !by_id_i) |-> ((pend_i & ((NUM_MB'(1) << idx_o) - NUM_MB'(1))) == '0));
endmodule

// File: rtl/can_mbox_filter.sv
module can_mbox_filter
  import mbx_pkg::*;
#(
  parameter int NUM_MB  = 16,
  parameter int STAMP_W = 16,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_MB)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rx_valid,
  input  logic [28:0]        rx_id,
  input  logic               rx_ide,
  input  logic               tx_done,
  output logic               rx_hit_valid,
  output logic [IDX_W-1:0]   rx_hit_idx,
  output logic [STAMP_W-1:0] rx_stamp,
  output logic               tx_next_valid,
  output logic [IDX_W-1:0]   tx_next_idx,
  output logic [NUM_MB-1:0]  irq_o,
  output logic [NUM_MB-1:0]  ovr_o
);
  localparam int NUM_MASK = 3;
  localparam int DED_LO   = NUM_MB - 2;

  logic rst_sync_n;

  mb_ctrl_t          ctrl_q [NUM_MB];
  mb_ctrl_t          ctrl_d [NUM_MB];
  logic [ID_W-1:0]   id_q   [NUM_MB];
  logic [ID_W-1:0]   mask_q [NUM_MASK];
  logic [ID_W-1:0]   mb_mask[NUM_MB];
  logic [KEY_W-1:0]  key    [NUM_MB];
  logic [NUM_MB-1:0] pend_vec;
  logic [NUM_MB-1:0] irq_q, irq_d, ovr_q, ovr_d;
  logic              by_id_q;
  logic [STAMP_W-1:0] timer_q;
  logic              eval_q, eval_d;

  logic              hit, any_match;
  logic [IDX_W-1:0]  hit_idx, first_idx;
  logic              pick_valid;
  logic [IDX_W-1:0]  pick_idx;

  logic wr_ctrl, wr_id, wr_mask, wr_cfg, rx_take, tx_fin;

  mbx_rst_sync i_rst_sync (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign wr_ctrl = wr_en && (wr_sel == WS_CTRL);
  assign wr_id   = wr_en && (wr_sel == WS_ID);
  assign wr_mask = wr_en && (wr_sel == WS_MASK) && (int'(wr_idx) < NUM_MASK);
  assign wr_cfg  = wr_en && (wr_sel == WS_CFG);
  assign rx_take = rx_valid && hit;
  assign tx_fin  = tx_done && tx_next_valid;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    if (g < DED_LO) begin : g_glob
      assign mb_mask[g] = mask_q[0];
    end else begin : g_ded
      assign mb_mask[g] = mask_q[g - DED_LO + 1];
    end
    assign key[g] = {ctrl_q[g].ext ? id_q[g] : {id_q[g][STD_W-1:0], {(ID_W-STD_W){1'b0}}},
                     ctrl_q[g].ext};
    assign pend_vec[g] = ctrl_q[g].code == MB_TX_PEND;
    assign irq_o[g]    = irq_q[g] && ctrl_q[g].ien;
  end

  assign ovr_o = ovr_q;

  mbx_rx_match #(.NUM_MB(NUM_MB)) i_rx_match (
    .clk(clk), .rst_n(rst_sync_n),
    .ctrl_i(ctrl_q), .id_i(id_q), .mask_i(mb_mask),
    .rx_id_i(rx_id), .rx_ide_i(rx_ide),
    .hit_o(hit), .hit_idx_o(hit_idx), .any_o(any_match), .first_idx_o(first_idx)
  );

  mbx_tx_pick #(.NUM_MB(NUM_MB)) i_tx_pick (
    .clk(clk), .rst_n(rst_sync_n),
    .pend_i(pend_vec), .key_i(key), .by_id_i(by_id_q),
    .valid_o(pick_valid), .idx_o(pick_idx)
  );

  // Next-state for buffer control, flags and re-evaluation request
  always_comb begin
    ctrl_d = ctrl_q;
    irq_d  = irq_q;
    ovr_d  = ovr_q;
    if (rx_valid) begin
      if (hit) begin
        ctrl_d[hit_idx].code = MB_RX_FULL;
        irq_d[hit_idx]       = 1'b1;
      end else if (any_match) begin
        ovr_d[first_idx] = 1'b1;
      end
    end
    if (tx_fin) begin
      ctrl_d[tx_next_idx].code = MB_OFF;
      irq_d[tx_next_idx]       = 1'b1;
    end
    if (wr_ctrl) begin
      ctrl_d[wr_idx].code = mb_code_e'(wr_data[1:0]);
      ctrl_d[wr_idx].ext  = wr_data[2];
      ctrl_d[wr_idx].ien  = wr_data[3];
      irq_d[wr_idx]       = 1'b0;
      ovr_d[wr_idx]       = 1'b0;
    end
    eval_d = tx_done || wr_ctrl || wr_cfg;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int i = 0; i < NUM_MB; i++) begin
        ctrl_q[i] <= '{code: MB_OFF, ext: 1'b0, ien: 1'b0};
        id_q[i]   <= '0;
      end
      for (int m = 0; m < NUM_MASK; m++) mask_q[m] <= '1;
      irq_q    <= '0;
      ovr_q    <= '0;
      by_id_q  <= 1'b0;
      timer_q  <= '0;
      eval_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      irq_q   <= irq_d;
      ovr_q   <= ovr_d;
      eval_q  <= eval_d;
      timer_q <= timer_q + STAMP_W'(1);
      if (wr_id)   id_q[wr_idx]        <= wr_data[ID_W-1:0];
      if (wr_mask) mask_q[wr_idx[1:0]] <= wr_data[ID_W-1:0];
      if (wr_cfg)  by_id_q             <= wr_data[0];
    end
  end

  // Receive result registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rx_hit_valid <= 1'b0;
      rx_hit_idx   <= '0;
      rx_stamp     <= '0;
    end else begin
      rx_hit_valid <= rx_take;
      if (rx_take) begin
        rx_hit_idx <= hit_idx;
        rx_stamp   <= timer_q;
      end
    end
  end

  // Transmit selection registers, enabled by the re-evaluation request
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      tx_next_valid <= 1'b0;
      tx_next_idx   <= '0;
    end else if (eval_q) begin
      tx_next_valid <= pick_valid;
      tx_next_idx   <= pick_idx;
    end
  end

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !eval_q |=> ($stable(tx_next_valid) && $stable(tx_next_idx)));

  // R4
  rx_marks_full_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rx_hit_valid |-> ((ctrl_q[rx_hit_idx].code == MB_RX_FULL) || $past(wr_ctrl)));

  // R11
  tx_done_retire_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (tx_fin && !wr_ctrl) |=> (ctrl_q[$past(tx_next_idx)].code == MB_OFF));

  // R5
  for (genvar g = 0; g < NUM_MB; g++) begin : g_ovr_chk
    ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $rose(ovr_q[g]) |-> ($past(rx_valid) && !rx_hit_valid));
  end
endmodule

// File: tb/test_can_mbox_filter.sv
module test_can_mbox_filter;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic        rx_valid;
  logic [28:0] rx_id;
  logic        rx_ide;
  logic        tx_done;
  logic        rx_hit_valid;
  logic [3:0]  rx_hit_idx;
  logic [15:0] rx_stamp;
  logic        tx_next_valid;
  logic [3:0]  tx_next_idx;
  logic [15:0] irq_o;
  logic [15:0] ovr_o;

  always #10 clk = ~clk;

  can_mbox_filter i_can_mbox_filter (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
    .wr_data(wr_data), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide),
    .tx_done(tx_done), .rx_hit_valid(rx_hit_valid), .rx_hit_idx(rx_hit_idx),
    .rx_stamp(rx_stamp), .tx_next_valid(tx_next_valid), .tx_next_idx(tx_next_idx),
    .irq_o(irq_o), .ovr_o(ovr_o)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Bench model
  logic [1:0]  m_code [16];
  logic        m_ext  [16];
  logic        m_ien  [16];
  logic [28:0] m_id   [16];
  logic [28:0] m_mask [3];
  logic        m_by_id;
  logic [15:0] m_irq, m_ovr;
  logic        e_tx_v;
  int          e_tx_idx;
  int          last_stamp_cyc;
  logic [15:0] last_stamp;
  bit          have_stamp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [29:0] m_key(input int i);
    return {m_ext[i] ? m_id[i] : {m_id[i][10:0], 18'b0}, m_ext[i]};
  endfunction

  task automatic model_tx();
    logic [29:0] best;
    e_tx_v = 0; e_tx_idx = 0; best = '0;
    for (int i = 0; i < 16; i++) begin
      if (m_code[i] == 2'd3 && (!e_tx_v || (m_by_id && m_key(i) < best))) begin
        e_tx_v = 1; e_tx_idx = i; best = m_key(i);
      end
    end
  endtask

  task automatic model_rx(input logic [28:0] rid, input logic rext,
                          output bit hit, output int hidx, output bit anym, output int fidx);
    logic [28:0] msk, diff;
    bit ok;
    hit = 0; hidx = 0; anym = 0; fidx = 0;
    for (int i = 0; i < 16; i++) begin
      msk  = (i < 14) ? m_mask[0] : m_mask[i - 13];
      diff = (rid ^ m_id[i]) & msk;
      ok = (m_code[i] == 2'd1 || m_code[i] == 2'd2) && (m_ext[i] == rext) &&
           (rext ? (diff == '0) : (diff[10:0] == '0));
      if (ok && !anym) begin anym = 1; fidx = i; end
      if (ok && m_code[i] == 2'd1 && !hit) begin hit = 1; hidx = i; end
    end
  endtask

  task automatic check_flags(input string req);
    logic [15:0] eirq;
    for (int i = 0; i < 16; i++) eirq[i] = m_irq[i] & m_ien[i];
    chk(irq_o == eirq, req, "irq_o", irq_o, eirq);
    chk(ovr_o == m_ovr, req, "ovr_o", ovr_o, m_ovr);
  endtask

  task automatic check_tx(input string req);
    chk(tx_next_valid == e_tx_v, req, "tx_next_valid", tx_next_valid, e_tx_v);
    if (e_tx_v) chk(int'(tx_next_idx) == e_tx_idx, req, "tx_next_idx", tx_next_idx, e_tx_idx);
  endtask

  // One write, then one more edge so transmit outputs settle
  task automatic do_wr(input logic [1:0] sel, input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_idx = idx; wr_data = data;
    @(negedge clk);
    wr_en = 0;
    case (sel)
      2'd0: begin
        m_code[idx] = data[1:0]; m_ext[idx] = data[2]; m_ien[idx] = data[3];
        m_irq[idx] = 0; m_ovr[idx] = 0;
      end
      2'd1: m_id[idx] = data[28:0];
      2'd2: if (idx < 3) m_mask[idx] = data[28:0];
      default: m_by_id = data[0];
    endcase
    if (sel == 2'd0 || sel == 2'd3) model_tx();
    @(negedge clk);
  endtask

  task automatic do_rx(input logic [28:0] rid, input logic rext, input string req);
    bit hit, anym;
    int hidx, fidx;
    model_rx(rid, rext, hit, hidx, anym, fidx);
    @(negedge clk);
    rx_valid = 1; rx_id = rid; rx_ide = rext;
    @(negedge clk);
    rx_valid = 0;
    if (hit) begin m_code[hidx] = 2'd2; m_irq[hidx] = 1; end
    else if (anym) m_ovr[fidx] = 1;
    chk(rx_hit_valid == hit, req, "rx_hit_valid", rx_hit_valid, hit);
    if (hit) begin
      chk(int'(rx_hit_idx) == hidx, req, "rx_hit_idx", rx_hit_idx, hidx);
      if (have_stamp)
        chk(16'(rx_stamp - last_stamp) == 16'(cyc - last_stamp_cyc), "R6", "stamp delta",
            16'(rx_stamp - last_stamp), 16'(cyc - last_stamp_cyc));
      have_stamp = 1; last_stamp = rx_stamp; last_stamp_cyc = cyc;
    end
    check_flags(req);
    @(negedge clk);
  endtask

  task automatic do_txdone();
    @(negedge clk);
    tx_done = 1;
    @(negedge clk);
    tx_done = 0;
    if (e_tx_v) begin m_code[e_tx_idx] = 2'd0; m_irq[e_tx_idx] = 1; end
    model_tx();
    @(negedge clk);
    check_tx("R11");
    check_flags("R11");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'h5eed_c0de));
    rst_n = 0; wr_en = 0; wr_sel = 0; wr_idx = 0; wr_data = 0;
    rx_valid = 0; rx_id = 0; rx_ide = 0; tx_done = 0;
    for (int i = 0; i < 16; i++) begin
      m_code[i] = 0; m_ext[i] = 0; m_ien[i] = 0; m_id[i] = 0;
    end
    for (int m = 0; m < 3; m++) m_mask[m] = '1;
    m_by_id = 0; m_irq = 0; m_ovr = 0; e_tx_v = 0; e_tx_idx = 0; have_stamp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(rx_hit_valid == 0, "R1", "rx_hit_valid reset", rx_hit_valid, 0);
    chk(tx_next_valid == 0, "R1", "tx_next_valid reset", tx_next_valid, 0);
    chk(irq_o == 0, "R1", "irq_o reset", irq_o, 0);
    chk(ovr_o == 0, "R1", "ovr_o reset", ovr_o, 0);

    // R7 all inactive: frame not taken
    do_rx(29'h20, 1'b1, "R7");

    // R3 dedicated mask on buffer 14, global mask exact on buffer 0
    do_wr(2'd2, 4'd1, {3'b0, ~29'hF});
    do_wr(2'd1, 4'd0, 32'h20);
    do_wr(2'd1, 4'd14, 32'h20);
    do_wr(2'd0, 4'd0, 32'hD);   // rx empty, extended, irq enabled
    do_wr(2'd0, 4'd14, 32'hD);
    do_rx(29'h23, 1'b1, "R3");  // only buffer 14 accepts
    do_rx(29'h23, 1'b0, "R2");  // format mismatch: no match
    do_rx(29'h20, 1'b1, "R4");  // buffer 0
    do_rx(29'h20, 1'b1, "R5");  // both full: overrun on buffer 0
    chk(ovr_o[0] == 1'b1, "R5", "ovr_o[0]", ovr_o[0], 1);
    do_wr(2'd2, 4'd3, 32'h0);   // ignored mask index
    do_wr(2'd0, 4'd0, 32'h1);   // buffer 0 empty, standard, no irq enable
    do_wr(2'd1, 4'd0, 32'h7FF);
    do_rx(29'h1FFFF7FF, 1'b0, "R2"); // upper bits ignored for standard
    chk(irq_o[0] == 1'b0, "R12", "gated irq", irq_o[0], 0);

    // R8 / R9 transmit priority
    do_wr(2'd1, 4'd3, 32'h5 << 18);
    do_wr(2'd1, 4'd7, 32'h5);
    do_wr(2'd0, 4'd3, 32'hF);   // tx pending, extended
    do_wr(2'd0, 4'd7, 32'hB);   // tx pending, standard
    check_tx("R8");
    chk(tx_next_idx == 4'd3, "R8", "lowest index", tx_next_idx, 3);
    do_wr(2'd3, 4'd0, 32'h1);
    check_tx("R9");
    chk(tx_next_idx == 4'd7, "R9", "standard wins tie", tx_next_idx, 7);
    do_wr(2'd1, 4'd3, (32'h5 << 18) - 1);
    check_tx("R10");
    chk(tx_next_idx == 4'd7, "R10", "id write no reselect", tx_next_idx, 7);
    do_wr(2'd0, 4'd9, 32'h0);   // control write triggers reselect
    check_tx("R9");
    chk(tx_next_idx == 4'd3, "R9", "lower key", tx_next_idx, 3);
    do_txdone();
    chk(tx_next_idx == 4'd7, "R11", "next after done", tx_next_idx, 7);

    // Random phase
    for (int n = 0; n < 400; n++) begin
      r = $urandom;
      case (r[2:0])
        3'd0, 3'd1: do_rx({25'h0, 4'($urandom)}, 1'($urandom), "R4");
        3'd2: begin
          do_wr(2'd0, 4'($urandom), {28'h0, 4'($urandom)});
          check_tx("R10");
          check_flags("R1");
        end
        3'd3: do_wr(2'd1, 4'($urandom), {28'h0, 4'($urandom)});
        3'd4: do_wr(2'd2, 4'($urandom), {3'b0, 25'h1FFFFFF, 4'($urandom)});
        3'd5: begin do_wr(2'd3, 4'd0, {31'h0, 1'($urandom)}); check_tx("R9"); end
        default: do_txdone();
      endcase
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule